// File: doc/BRIEF.md
# Carry-Free Quaternary Signed-Digit Adder/Subtractor

This block adds or subtracts two numbers held in quaternary signed-digit form. Each digit is a value from -3 to +3, stored as a 3-bit two's complement field. Because the representation is redundant, a carry never moves more than one digit position. The delay from any input to any output is therefore the same at every word length.

Addition takes two passes, both purely combinational. In the first pass each column's digit pair is added and then recoded into a small carry and a small residue. In the second pass each residue is added to the carry coming from the column just below. When subtraction is selected, each digit of the second operand is negated before the first pass. The block has no clock and no state, and its result is valid after one combinational delay.

Top module: `qsd_addsub`

## Requirements
- R1: A vector holds NDIG digits (4 by default). Digit i sits at bits [3i+2:3i], and digit 0 is the least significant with weight 4^i. Each digit uses 3-bit two's complement: -3=101, -2=110, -1=111, 0=000, 1=001, 2=010, 3=011. The pattern 100 never appears on an output when the inputs are valid.
- R2: With `sub_i`=0, value(`res_o`) + `cout_o`·4^NDIG equals value(`a_i`) + value(`b_i`).
- R3: With `sub_i`=1, value(`res_o`) + `cout_o`·4^NDIG equals value(`a_i`) − value(`b_i`).
- R4: Every result digit lies in -3..+3.
- R5: The carry-out digit `cout_o` lies in -1..+1 and is 3 bits wide.
- R6: Let s be the column sum of digit i. Recoding gives carry 0 and residue s when s is in -2..2. It gives carry +1 and residue s−4 when s ≥ 3, and carry −1 and residue s+4 when s ≤ −3. Digit 0 of the result equals its own residue, because the lowest column receives carry 0.
- R7: For i ≥ 1, result digit i equals the residue of column i plus the carry of column i−1.
- R8: `cout_o` equals the recoding carry of the most significant column.
- R9: Adding digits (1,3,0,1) and (1,2,2,3), most significant first, gives (3,1,3,0) with carry-out 0.
- R10: Subtracting (2,0,0,0) from (1,3,3,3) gives (0,0,0,−1) with carry-out 0.
- R11: Changing only digit j of one operand leaves every result digit outside positions j and j+1 unchanged. It also leaves `cout_o` unchanged when j < NDIG−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 3*NDIG | First operand, signed-digit vector |
| b_i | input | 3*NDIG | Second operand, signed-digit vector |
| sub_i | input | 1 | 1 selects a_i − b_i, 0 selects a_i + b_i |
| res_o | output | 3*NDIG | Result digits |
| cout_o | output | 3 | Carry-out digit, -1..+1 |

## Verification
The block holds no state, so any wrong recode shows at the ports as soon as the inputs settle. An error in column i can only corrupt result digit i, result digit i+1, or the carry-out, and this locality tells which column is at fault. The bench therefore compares each digit with a per-column model. It also checks the overall integer value, so a compensating pair of errors cannot go unnoticed. Finally, it changes a single digit and confirms that columns further away do not move.

// File: rtl/qsd_pkg.sv
package qsd_pkg;
    localparam int DIG_W = 3;
    typedef logic signed [DIG_W-1:0] qdigit_t;
    typedef struct packed {
        qdigit_t carry;
        qdigit_t resid;
    } qrec_t;
endpackage

// File: rtl/qsd_digit_neg.sv
module qsd_digit_neg
    import qsd_pkg::*;
(
    input  qdigit_t din,
    input  logic    neg_en,
    output qdigit_t dout
);
    qdigit_t dout_d;
    always_comb begin
        dout_d = neg_en ? qdigit_t'(-din) : din;
    end
    assign dout = dout_d;
endmodule

// File: rtl/qsd_recode.sv
module qsd_recode
    import qsd_pkg::*;
(
    input  qdigit_t x,
    input  qdigit_t y,
    output qrec_t   rec
);
    logic signed [DIG_W:0] colsum_d;
    logic signed [DIG_W:0] adj_d;
    qrec_t rec_d;

    always_comb begin
        colsum_d = {x[DIG_W-1], x} + {y[DIG_W-1], y};
        rec_d    = '0;
        adj_d    = colsum_d;
        if (colsum_d >= 4'sd3) begin
            adj_d       = colsum_d - 4'sd4;
            rec_d.carry = 3'sd1;
        end else if (colsum_d <= -4'sd3) begin
            adj_d       = colsum_d + 4'sd4;
            rec_d.carry = -3'sd1;
        end
        rec_d.resid = adj_d[DIG_W-1:0];
    end
    assign rec = rec_d;
endmodule

// File: rtl/qsd_gather.sv
module qsd_gather
    import qsd_pkg::*;
(
    input  qdigit_t resid,
    input  qdigit_t cin,
    output qdigit_t dout
);
    qdigit_t dout_d;
    always_comb begin
        dout_d = resid + cin;
    end
    assign dout = dout_d;
endmodule

// File: rtl/qsd_addsub.sv
module qsd_addsub
    import qsd_pkg::*;
#(
    parameter int NDIG = 4
) (
    input  logic [3*NDIG-1:0] a_i,
    input  logic [3*NDIG-1:0] b_i,
    input  logic              sub_i,
    output logic [3*NDIG-1:0] res_o,
    output logic [2:0]        cout_o
);
    localparam int VEC_W = DIG_W * NDIG;

    qdigit_t opb_d [NDIG];
    qrec_t   rec_d [NDIG];
    qdigit_t res_d [NDIG];

    for (genvar i = 0; i < NDIG; i++) begin : g_col
        qsd_digit_neg u_neg (
            .din    (b_i[DIG_W*i +: DIG_W]),
            .neg_en (sub_i),
            .dout   (opb_d[i])
        );
        qsd_recode u_rec (
            .x   (a_i[DIG_W*i +: DIG_W]),
            .y   (opb_d[i]),
            .rec (rec_d[i])
        );
        if (i == 0) begin : g_lsd
            qsd_gather u_gat (
                .resid (rec_d[i].resid),
                .cin   ('0),
                .dout  (res_d[i])
            );
        end else begin : g_upper
            qsd_gather u_gat (
                .resid (rec_d[i].resid),
                .cin   (rec_d[i-1].carry),
                .dout  (res_d[i])
            );
        end
        assign res_o[DIG_W*i +: DIG_W] = res_d[i];
    end

    assign cout_o = rec_d[NDIG-1].carry;

    logic [VEC_W-1:0] unused_chk;
    assign unused_chk = res_o;
endmodule

// File: rtl/qsd_addsub_chk.sv
module qsd_addsub_chk #(
    parameter int NDIG = 4
) (
    input logic [3*NDIG-1:0] a_i,
    input logic [3*NDIG-1:0] b_i,
    input logic              sub_i,
    input logic [3*NDIG-1:0] res_o,
    input logic [2:0]        cout_o
);
    localparam int SCALE = 1 << (2 * NDIG);

    function automatic int vec_val(input logic [3*NDIG-1:0] v);
        int acc = 0;
        for (int i = NDIG - 1; i >= 0; i--)
            acc = acc * 4 + int'($signed(v[3*i +: 3]));
        return acc;
    endfunction

    function automatic logic vec_ok(input logic [3*NDIG-1:0] v);
        logic ok = 1'b1;
        for (int i = 0; i < NDIG; i++)
            if (v[3*i +: 3] == 3'b100) ok = 1'b0;
        return ok;
    endfunction

    logic in_ok;
    int   lhs;
    assign in_ok = vec_ok(a_i) && vec_ok(b_i);
    assign lhs   = vec_val(res_o) + int'($signed(cout_o)) * SCALE;

    always_comb begin
        if (in_ok) begin
            AST_DIGIT_RANGE: assert (vec_ok(res_o)) else $error("result digit out of range"); // R4
            AST_COUT_RANGE: assert (cout_o == 3'b000 || cout_o == 3'b001 || cout_o == 3'b111) else $error("carry-out out of range"); // R5
            if (!sub_i) begin
                AST_ADD_VALUE: assert (lhs == vec_val(a_i) + vec_val(b_i)) else $error("sum value wrong"); // R2
            end else begin
                AST_SUB_VALUE: assert (lhs == vec_val(a_i) - vec_val(b_i)) else $error("difference value wrong"); // R3
            end
        end
    end
endmodule

bind qsd_addsub qsd_addsub_chk #(.NDIG(NDIG)) u_chk (
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (sub_i),
    .res_o  (res_o),
    .cout_o (cout_o)
);

// File: tb/qsd_addsub_tb.sv
`timescale 1ns/1ps
module qsd_addsub_tb;
    localparam int NDIG  = 4;
    localparam int VW    = 3 * NDIG;
    localparam int SCALE = 1 << (2 * NDIG);
    localparam int NVEC  = 10;

    localparam logic [2:0] M3 = 3'b101, M2 = 3'b110, M1 = 3'b111, Z0 = 3'b000;
    localparam logic [2:0] P1 = 3'b001, P2 = 3'b010, P3 = 3'b011;

    // {sub, a, b, expected result, expected carry-out}, digits MSD first
    localparam logic [39:0] VECS [NVEC] = '{
        {1'b0, P1,P3,Z0,P1, P1,P2,P2,P3, P3,P1,P3,Z0, Z0},
        {1'b1, P1,P3,P3,P3, P2,Z0,Z0,Z0, Z0,Z0,Z0,M1, Z0},
        {1'b0, P3,P3,P3,P3, P3,P3,P3,P3, P3,P3,P3,P2, P1},
        {1'b0, M3,M3,M3,M3, M3,M3,M3,M3, M3,M3,M3,M2, M1},
        {1'b1, P3,P3,P3,P3, M3,M3,M3,M3, P3,P3,P3,P2, P1},
        {1'b0, Z0,Z0,Z0,Z0, Z0,Z0,Z0,Z0, Z0,Z0,Z0,Z0, Z0},
        {1'b0, Z0,Z0,Z0,P2, Z0,Z0,Z0,P1, Z0,Z0,P1,M1, Z0},
        {1'b0, P2,M1,P1,M2, P2,M1,P1,M1, Z0,M2,P1,P1, P1},
        {1'b1, Z0,Z0,Z0,Z0, Z0,Z0,Z0,P3, Z0,Z0,M1,P1, Z0},
        {1'b0, M2,M2,M2,M2, M1,M1,M1,M1, Z0,Z0,Z0,P1, M1}
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [VW-1:0] a, b, res;
    logic          sub;
    logic [2:0]    cout;
    int checks = 0, fails = 0;
    logic done = 1'b0;

    qsd_addsub #(.NDIG(NDIG)) u_dut (
        .a_i(a), .b_i(b), .sub_i(sub), .res_o(res), .cout_o(cout)
    );

    function automatic int dv(input logic [2:0] d);
        return int'($signed(d));
    endfunction

    function automatic int vval(input logic [VW-1:0] v);
        int acc = 0;
        for (int i = NDIG - 1; i >= 0; i--) acc = acc * 4 + dv(v[3*i +: 3]);
        return acc;
    endfunction

    function automatic logic [2:0] rnd_digit();
        int r = int'($urandom_range(6)) - 3;
        return r[2:0];
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(input logic s, input logic [VW-1:0] av, input logic [VW-1:0] bv);
        @(negedge clk);
        sub = s; a = av; b = bv;
        @(posedge clk);
    endtask

    // per-column model from R6/R7/R8
    task automatic check_model(input string tag);
        int s, c [NDIG], rr [NDIG], bd, total;
        for (int i = 0; i < NDIG; i++) begin
            bd = dv(b[3*i +: 3]);
            s  = dv(a[3*i +: 3]) + (sub ? -bd : bd);
            if (s >= 3)       begin c[i] = 1;  rr[i] = s - 4; end
            else if (s <= -3) begin c[i] = -1; rr[i] = s + 4; end
            else              begin c[i] = 0;  rr[i] = s;     end
        end
        chk({tag, " R6 digit0"}, dv(res[2:0]), rr[0]);
        for (int i = 1; i < NDIG; i++)
            chk({tag, " R7 digit"}, dv(res[3*i +: 3]), rr[i] + c[i-1]);
        chk({tag, " R8 cout"}, dv(cout), c[NDIG-1]);
        for (int i = 0; i < NDIG; i++)
            chk({tag, " R1 R4 range"}, int'(res[3*i +: 3] == 3'b100), 0);
        chk({tag, " R5 cout range"}, int'(dv(cout) >= -1 && dv(cout) <= 1), 1);
        total = sub ? vval(a) - vval(b) : vval(a) + vval(b);
        chk(sub ? {tag, " R3 value"} : {tag, " R2 value"}, vval(res) + dv(cout) * SCALE, total);
    endtask

    initial begin
        sub = 1'b0; a = '0; b = '0;
        @(posedge clk);
        chk("R2 zero inputs res", int'(res), 0);
        chk("R5 zero inputs cout", int'(cout), 0);

        for (int k = 0; k < NVEC; k++) begin
            apply(VECS[k][39], VECS[k][38:27], VECS[k][26:15]);
            chk(k == 0 ? "R9 table res" : (k == 1 ? "R10 table res" : "R2 R3 table res"),
                int'(res), int'(VECS[k][14:3]));
            chk("R5 R8 table cout", int'(cout), int'(VECS[k][2:0]));
            check_model("table");
        end

        for (int n = 0; n < 400; n++) begin
            logic [VW-1:0] ra, rb;
            for (int i = 0; i < NDIG; i++) begin
                ra[3*i +: 3] = rnd_digit();
                rb[3*i +: 3] = rnd_digit();
            end
            apply(1'($urandom_range(1)), ra, rb);
            check_model("random");
        end

        // R11 locality
        for (int n = 0; n < 60; n++) begin
            logic [VW-1:0] ra, rb, res0;
            logic [2:0] c0, nd;
            logic s;
            int j;
            for (int i = 0; i < NDIG; i++) begin
                ra[3*i +: 3] = rnd_digit();
                rb[3*i +: 3] = rnd_digit();
            end
            s = 1'($urandom_range(1));
            j = int'($urandom_range(NDIG - 1));
            apply(s, ra, rb);
            res0 = res; c0 = cout;
            nd = rnd_digit();
            ra[3*j +: 3] = nd;
            apply(s, ra, rb);
            for (int i = 0; i < NDIG; i++)
                if (i != j && i != j + 1)
                    chk("R11 far digit unchanged", dv(res[3*i +: 3]), dv(res0[3*i +: 3]));
            if (j < NDIG - 1) chk("R11 cout unchanged", dv(cout), dv(c0));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule